// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial slave front end of a byte-wide non-volatile store. Once the front end has received a write request and its two address bytes, it announces the start address. The block then gathers the incoming data bytes into a 32-byte page buffer and answers each byte with an accept or reject pulse, which the front end turns into an ACK or NoACK. When the transaction closes with a STOP, the block copies every buffered byte into the storage array in one internal write cycle of fixed length. It reports busy for the whole of that cycle so the front end can refuse new traffic.

The start address is split into two fields. The upper bits pick the page and stay latched for the whole transaction. The low five bits are the position inside the page. Each accepted byte advances the position, and the position wraps inside the same page, so a long burst overwrites bytes it loaded earlier.

A protect pin is sampled once per transaction, on the first SCL falling edge reported after the start address. If it is high at that moment, the whole request is refused. Each buffer slot carries a valid bit, so the commit touches only the locations that were actually loaded. The array powers up erased, with every byte equal to FFh, and has a one-cycle read port for the read side of the device.

Top module: `pgwr_commit`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, busy_o, byte_ack_o, byte_nak_o and wr_en_o are all 0.
- R2: Each accepted byte is stored in the buffer at the current in-page position, which is start_addr_i[4:0] for the first byte and then increases by one per accepted byte, wrapping from 31 to 0. A later byte at the same position replaces the earlier one.
- R3: The commit writes to the page given by start_addr_i[ADDR_W-1:5] only, and only to positions that received a byte. All other array locations keep their contents.
- R4: A stop_stb_i that arrives after at least one accepted byte raises busy_o in the next cycle, and busy_o then stays high for exactly WR_CYCLES cycles.
- R5: wr_en_o is high only while busy_o is high. Every write within one commit stays inside the latched page.
- R6: wp_i is sampled at the first scl_fall_i after txn_begin_i. If it is 1 at that sample, every byte of the transaction is rejected, no commit starts, and the array is unchanged.
- R7: Once wp_i has been sampled as 0, later changes of wp_i have no effect on the transaction.
- R8: abort_stb_i (repeated START), or a stop_stb_i with no accepted byte, empties the buffer and starts no commit. Bytes from that transaction never reach the array.
- R9: A byte strobe during busy_o, or outside an open transaction, is rejected and changes nothing. A txn_begin_i during busy_o is ignored.
- R10: Every array byte reads FFh before it is first written. rd_data_o shows the byte at rd_addr_i one cycle after the address is presented.
- R11: Each byte_stb_i is answered in the next cycle by exactly one pulse, either on byte_ack_o or on byte_nak_o. Neither output pulses without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_begin_i | input | 1 | Pulse: write transaction opened, start address valid |
| start_addr_i | input | ADDR_W | Start address: page in upper bits, in-page position in bits 4:0 |
| byte_stb_i | input | 1 | Pulse: one data byte received |
| byte_data_i | input | 8 | Data byte qualified by byte_stb_i |
| stop_stb_i | input | 1 | Pulse: STOP seen on the bus |
| abort_stb_i | input | 1 | Pulse: repeated START seen on the bus |
| scl_fall_i | input | 1 | Pulse: SCL falling edge |
| wp_i | input | 1 | Write-protect pin, 1 protects the whole array |
| rd_addr_i | input | ADDR_W | Array read address |
| busy_o | output | 1 | Internal write cycle in progress |
| byte_ack_o | output | 1 | Pulse: previous byte accepted |
| byte_nak_o | output | 1 | Pulse: previous byte rejected |
| wr_en_o | output | 1 | Array write enable |
| wr_addr_o | output | ADDR_W | Array write address |
| wr_data_o | output | 8 | Array write data |
| rd_data_o | output | 8 | Array read data, one cycle after rd_addr_i |

## Verification
The assertions check the handshake rules on every cycle. Each byte strobe gets exactly one ack or nak in the next cycle, and neither pulses on its own. A byte strobe during a commit gets a nak. Busy starts only from a STOP and lasts exactly WR_CYCLES cycles. Array writes happen only under busy and stay on one page. What ends up in the array can only be shown by the bench's scenarios, which read it back and compare against a reference model. These cover in-page wrap and overwrite, untouched neighbours in a partly loaded page, a protect pin that is high at the sample or only goes high afterwards, and buffers emptied by an abort or an empty STOP.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int BYTE_W = 8;

    // Phase of the collector: waiting, gathering bytes, or committing
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_BUSY = 2'd2
    } phase_e;

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [OFF_W-1:0]  load_off_i,
    input  logic [BYTE_W-1:0] load_data_i,
    input  logic [OFF_W-1:0]  slot_idx_i,
    output logic              slot_valid_o,
    output logic [BYTE_W-1:0] slot_data_o,
    output logic              any_valid_o
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][BYTE_W-1:0] dat;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr_i) begin
            buf_d.vld = '0;
        end
        if (load_i) begin
            buf_d.vld[load_off_i] = 1'b1;
            buf_d.dat[load_off_i] = load_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign slot_valid_o = buf_q.vld[slot_idx_i];
    assign slot_data_o  = buf_q.dat[slot_idx_i];
    assign any_valid_o  = |buf_q.vld;

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int TMR_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_stb_i,
    input  logic              stop_stb_i,
    input  logic              abort_stb_i,
    input  logic              scl_fall_i,
    input  logic              wp_i,
    input  logic              slot_valid_i,
    input  logic              any_valid_i,
    output logic              buf_clr_o,
    output logic              buf_load_o,
    output logic [OFF_W-1:0]  load_off_o,
    output logic [OFF_W-1:0]  slot_idx_o,
    output logic              busy_o,
    output logic              byte_ack_o,
    output logic              byte_nak_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o
);

    typedef struct packed {
        phase_e           phase;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic             prot;
        logic             armed;
        logic [TMR_W-1:0] tmr;
        logic             ack;
        logic             nak;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  eff_prot;

    // Protect level that applies to a byte arriving now
    assign eff_prot = ctl_q.armed ? wp_i : ctl_q.prot;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ack  = 1'b0;
        ctl_d.nak  = byte_stb_i;
        buf_clr_o  = 1'b0;
        buf_load_o = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (txn_begin_i) begin
                    ctl_d.phase = PH_OPEN;
                    ctl_d.page  = start_addr_i[ADDR_W-1:OFF_W];
                    ctl_d.off   = start_addr_i[OFF_W-1:0];
                    ctl_d.prot  = 1'b0;
                    ctl_d.armed = 1'b1;
                    buf_clr_o   = 1'b1;
                end
            end
            PH_OPEN: begin
                if (abort_stb_i) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.armed = 1'b0;
                    buf_clr_o   = 1'b1;
                end else if (stop_stb_i) begin
                    ctl_d.armed = 1'b0;
                    if (any_valid_i && !ctl_q.prot) begin
                        ctl_d.phase = PH_BUSY;
                        ctl_d.tmr   = '0;
                    end else begin
                        ctl_d.phase = PH_IDLE;
                        buf_clr_o   = 1'b1;
                    end
                end else if (txn_begin_i) begin
                    ctl_d.page  = start_addr_i[ADDR_W-1:OFF_W];
                    ctl_d.off   = start_addr_i[OFF_W-1:0];
                    ctl_d.prot  = 1'b0;
                    ctl_d.armed = 1'b1;
                    buf_clr_o   = 1'b1;
                end else begin
                    if (scl_fall_i && ctl_q.armed) begin
                        ctl_d.prot  = wp_i;
                        ctl_d.armed = 1'b0;
                    end
                    if (byte_stb_i) begin
                        ctl_d.armed = 1'b0;
                        ctl_d.prot  = eff_prot;
                        if (!eff_prot) begin
                            ctl_d.nak  = 1'b0;
                            ctl_d.ack  = 1'b1;
                            buf_load_o = 1'b1;
                            ctl_d.off  = ctl_q.off + 1'b1;
                        end
                    end
                end
            end
            PH_BUSY: begin
                ctl_d.tmr = ctl_q.tmr + 1'b1;
                if (ctl_q.tmr == TMR_W'(WR_CYCLES - 1)) begin
                    ctl_d.phase = PH_IDLE;
                    buf_clr_o   = 1'b1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_off_o = ctl_q.off;
    assign slot_idx_o = ctl_q.tmr[OFF_W-1:0];
    assign busy_o     = (ctl_q.phase == PH_BUSY);
    assign byte_ack_o = ctl_q.ack;
    assign byte_nak_o = ctl_q.nak;
    assign wr_en_o    = busy_o && (ctl_q.tmr < TMR_W'(PAGE_BYTES)) && slot_valid_i;
    assign wr_addr_o  = {ctl_q.page, ctl_q.tmr[OFF_W-1:0]};

endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Erased state at power-up
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
        rd_data_o <= mem_q[rd_addr_i];
    end

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_stb_i,
    input  logic [7:0]        byte_data_i,
    input  logic              stop_stb_i,
    input  logic              abort_stb_i,
    input  logic              scl_fall_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              busy_o,
    output logic              byte_ack_o,
    output logic              byte_nak_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic [7:0]        rd_data_o
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic             buf_clr;
    logic             buf_load;
    logic [OFF_W-1:0] load_off;
    logic [OFF_W-1:0] slot_idx;
    logic             slot_valid;
    logic             any_valid;

    pgwr_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .WR_CYCLES (WR_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_begin_i (txn_begin_i),
        .start_addr_i(start_addr_i),
        .byte_stb_i  (byte_stb_i),
        .stop_stb_i  (stop_stb_i),
        .abort_stb_i (abort_stb_i),
        .scl_fall_i  (scl_fall_i),
        .wp_i        (wp_i),
        .slot_valid_i(slot_valid),
        .any_valid_i (any_valid),
        .buf_clr_o   (buf_clr),
        .buf_load_o  (buf_load),
        .load_off_o  (load_off),
        .slot_idx_o  (slot_idx),
        .busy_o      (busy_o),
        .byte_ack_o  (byte_ack_o),
        .byte_nak_o  (byte_nak_o),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o)
    );

    pgwr_buffer #(
        .PAGE_BYTES(PAGE_BYTES)
    ) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (buf_clr),
        .load_i      (buf_load),
        .load_off_i  (load_off),
        .load_data_i (byte_data_i),
        .slot_idx_i  (slot_idx),
        .slot_valid_o(slot_valid),
        .slot_data_o (wr_data_o),
        .any_valid_o (any_valid)
    );

    pgwr_array #(
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk      (clk),
        .wr_en_i  (wr_en_o),
        .wr_addr_i(wr_addr_o),
        .wr_data_i(wr_data_o),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o)
    );

endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(WR_CYCLES + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_stb_i,
    input logic              stop_stb_i,
    input logic              busy_o,
    input logic              byte_ack_o,
    input logic              byte_nak_o,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o
);

    logic [CNT_W-1:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (busy_o) begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
        end else begin
            busy_cnt_q <= '0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!busy_o && !byte_ack_o && !byte_nak_o && !wr_en_o));

    p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_stb_i));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt_q == CNT_W'(WR_CYCLES)));

    p_wr_under_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    p_wr_same_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && busy_o && $past(wr_en_o)) |->
            (wr_addr_o[ADDR_W-1:OFF_W] == $past(wr_addr_o[ADDR_W-1:OFF_W])));

    p_nak_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byte_stb_i) |=> (byte_nak_o && !byte_ack_o));

    p_one_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb_i |=> ($countones({byte_ack_o, byte_nak_o}) == 1));

    p_no_stray_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ack_o || byte_nak_o) |-> $past(byte_stb_i));

endmodule

bind pgwr_commit pgwr_commit_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb_i(byte_stb_i),
    .stop_stb_i(stop_stb_i),
    .busy_o    (busy_o),
    .byte_ack_o(byte_ack_o),
    .byte_nak_o(byte_nak_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o)
);

// File: tb/pgwr_commit_bench.sv
module pgwr_commit_bench;

    localparam int AW    = 11;
    localparam int PG    = 32;
    localparam int WR    = 40;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_begin = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_stb = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop_stb = 1'b0;
    logic          abort_stb = 1'b0;
    logic          scl_fall = 1'b0;
    logic          wp = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy;
    logic          ack;
    logic          nak;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    pgwr_commit #(.ADDR_W(AW), .PAGE_BYTES(PG), .WR_CYCLES(WR)) u_pgwr_commit (
        .clk(clk), .rst_n(rst_n), .txn_begin_i(txn_begin), .start_addr_i(start_addr),
        .byte_stb_i(byte_stb), .byte_data_i(byte_data), .stop_stb_i(stop_stb),
        .abort_stb_i(abort_stb), .scl_fall_i(scl_fall), .wp_i(wp), .rd_addr_i(rd_addr),
        .busy_o(busy), .byte_ack_o(ack), .byte_nak_o(nak), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_data_o(rd_data)
    );

    function automatic logic [AW-1:0] slot_addr(logic [AW-1:0] base, int pos);
        return {base[AW-1:5], 5'(pos)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string tag);
        rd_addr = a;
        @(negedge clk);
        chk(tag, 32'(rd_data), 32'(ref_mem[a]));
    endtask

    // One transaction: end_kind 0 = STOP, 1 = repeated START
    task automatic run_txn(input logic [AW-1:0] sa, input int nbytes, input logic wp_s,
                           input logic wp_l, input int end_kind, input bit poke);
        logic [7:0] pbuf [PG];
        bit         pv [PG];
        logic [4:0] off;
        int         cnt;
        bit         commit;
        for (int j = 0; j < PG; j++) begin pbuf[j] = '0; pv[j] = 0; end
        txn_begin = 1'b1; start_addr = sa;
        @(negedge clk);
        txn_begin = 1'b0;
        wp = wp_s; scl_fall = 1'b1;
        @(negedge clk);
        scl_fall = 1'b0; wp = wp_l;
        off = sa[4:0];
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            byte_stb = 1'b1; byte_data = d;
            @(negedge clk);
            byte_stb = 1'b0;
            chk(wp_s ? "R6 nak when protected" : "R7 ack after low sample", 32'(ack), 32'(!wp_s));
            chk("R11 nak output", 32'(nak), 32'(wp_s));
            if (!wp_s) begin pbuf[off] = d; pv[off] = 1; off = off + 5'd1; end
        end
        commit = (end_kind == 0) && (nbytes > 0) && !wp_s;
        if (end_kind == 0) stop_stb = 1'b1; else abort_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0; abort_stb = 1'b0;
        chk(commit ? "R4 busy after stop" : "R8 no busy", 32'(busy), 32'(commit));
        if (commit) begin
            cnt = 0;
            while (busy && cnt < 1000) begin
                cnt++;
                if (poke && cnt == 1) begin
                    byte_stb = 1'b1; txn_begin = 1'b1; start_addr = ~sa;
                end
                @(negedge clk);
                if (poke && cnt == 1) begin
                    byte_stb = 1'b0; txn_begin = 1'b0;
                    chk("R9 nak during busy", 32'({ack, nak}), 32'b01);
                end
            end
            chk("R4 busy length", 32'(cnt), 32'(WR));
            for (int j = 0; j < PG; j++) if (pv[j]) ref_mem[slot_addr(sa, j)] = pbuf[j];
        end
        wp = 1'b0;
        // R2 R3 R5 R6 R8: whole page compared with the model
        for (int j = 0; j < PG; j++) read_chk(slot_addr(sa, j), "R3 page contents");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 answers in reset", 32'({ack, nak, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 quiet after reset", 32'({busy, ack, nak, wr_en}), 0);
        read_chk('0, "R10 erased low");
        read_chk(AW'(DEPTH - 1), "R10 erased high");

        // R9: byte outside any transaction
        byte_stb = 1'b1; byte_data = 8'h3C;
        @(negedge clk);
        byte_stb = 1'b0;
        chk("R9 nak outside txn", 32'({ack, nak}), 32'b01);

        run_txn(11'h045, 1, 1'b0, 1'b0, 0, 1'b0);    // R2 R4 single byte
        run_txn(11'h074, 40, 1'b0, 1'b0, 0, 1'b0);   // R2 wrap and overwrite
        run_txn(11'h10A, 5, 1'b0, 1'b0, 0, 1'b1);    // R3 partial page, R9 poke
        // R9: the ignored begin during busy left no open transaction
        byte_stb = 1'b1;
        @(negedge clk);
        byte_stb = 1'b0;
        chk("R9 nak after busy", 32'({ack, nak}), 32'b01);
        read_chk(~11'h10A, "R9 begin ignored");
        run_txn(11'h200, 6, 1'b1, 1'b0, 0, 1'b0);    // R6 protected
        run_txn(11'h260, 4, 1'b0, 1'b1, 0, 1'b0);    // R7 late protect
        run_txn(11'h300, 0, 1'b0, 1'b0, 0, 1'b0);    // R8 empty stop
        run_txn(11'h341, 7, 1'b0, 1'b0, 1, 1'b0);    // R8 abort
        run_txn(11'h350, 1, 1'b0, 1'b0, 0, 1'b0);    // R8 stale bytes gone

        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a;
            int            nb;
            a  = AW'($urandom);
            nb = int'($urandom_range(0, 40));
            run_txn(a, nb, ($urandom_range(0, 3) == 0), 1'($urandom),
                    ($urandom_range(0, 4) == 0) ? 1 : 0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule